// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a CAN bit sampler and the frame parser. The sampler presents one raw line bit per strobe. Logic 0 is dominant and logic 1 is recessive. A transmitter inserts a complementary bit after every run of five equal bits. This block recognises those inserted bits and removes them from the stream. Each remaining frame bit goes to the parser with its own strobe and a running frame-bit index. Each removed bit is reported on a separate one-cycle flag instead.

The run history is kept on raw line bits, so a removed stuff bit starts the next run itself. The sampler marks the start-of-frame bit, which clears the history and resets the index to zero. In the fixed-form tail of a frame (CRC delimiter, acknowledge slot and delimiter, end of frame), stuffing is not used. During that tail the parser raises a bypass input, and every raw bit is then forwarded untouched. When checking is active and a sixth equal bit arrives, the block forwards that bit and pulses a stuff-error flag alongside it. All outputs are registered, one cycle after the input strobe.

Top module: `can_destuffer`

## Requirements
- R1: While rst_n is low and after its release with no input strobe, out_valid, stuff_flag and stuff_error are 0.
- R2: Each accepted bit that is not a stuff bit appears on out_bit with out_valid high exactly one clock after the cycle where in_valid was high.
- R3: With bypass low, if the last RUN_LIMIT (default 5) raw bits were equal and the new bit differs, the new bit is dropped: out_valid stays low and stuff_flag pulses one cycle later.
- R4: out_index is 0 for the start-of-frame bit and grows by one for each later forwarded bit; stuff bits do not advance it.
- R5: A removed stuff bit counts as the first bit of a new run, so four further equal bits after it make the next opposite bit a stuff bit.
- R6: A bit strobed with in_sof high clears the run history and is always forwarded with index 0, never flagged. It counts as the first bit of a new run, whatever came before.
- R7: With bypass low, a bit equal to the previous RUN_LIMIT equal bits is forwarded with stuff_error high in that same output cycle, and the run restarts at length one.
- R8: With stuff_disable high, every strobed bit is forwarded; stuff_flag and stuff_error stay low. The run history keeps counting and saturates at RUN_LIMIT.
- R9: Cycles with in_valid low produce no output strobe and leave the run and index state unchanged, whatever in_bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw bit strobe from the sampler |
| in_bit | input | 1 | Raw sampled line bit (0 dominant) |
| in_sof | input | 1 | Marks the strobed bit as start of frame |
| stuff_disable | input | 1 | Parser bypass for the fixed-form frame tail |
| out_valid | output | 1 | Frame bit strobe |
| out_bit | output | 1 | Destuffed frame bit |
| out_index | output | IDX_W | Frame-bit index of out_bit |
| stuff_flag | output | 1 | Pulses for a removed stuff bit |
| stuff_error | output | 1 | Pulses with a forwarded sixth equal bit |

## Verification
The stuff-error pulse and the forwarding of a frame bit fall in the same output cycle. A sixth equal bit is both passed on and reported as a violation. This is provoked with a start-of-frame bit followed by five more dominant bits. The violating bit must appear with its own index and the error flag set together. The same coincidence is also provoked right after the bypass is released on a saturated run. There, the first checked bit must carry both the forwarded value and the error.

// File: rtl/can_dstf_pkg.sv
package can_dstf_pkg;

  // Classification of one strobed raw bit
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,   // no strobe this cycle
    BK_FRAME = 2'd1,   // forwarded frame bit
    BK_STUFF = 2'd2,   // removed stuff bit
    BK_VIOL  = 2'd3    // forwarded bit that breaks the run rule
  } bit_kind_e;

  function automatic logic kind_forwards(bit_kind_e k);
    return (k == BK_FRAME) || (k == BK_VIOL);
  endfunction

endpackage

// File: rtl/can_dstf_run.sv
// Tracks the length and value of the current run of equal raw bits.
module can_dstf_run
  import can_dstf_pkg::*;
#(
  parameter int RUN_LIMIT = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      in_bit,
  input  logic      in_sof,
  input  bit_kind_e kind,
  output logic      run_full,
  output logic      last_bit
);

  localparam int CNT_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;
  logic             run_en;

  assign run_en = in_valid;

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (in_valid) begin
      last_d = in_bit;
      if (in_sof || (kind == BK_STUFF) || (kind == BK_VIOL) || (in_bit != last_q)) begin
        cnt_d = ONE_CNT;
      end else if (cnt_q != FULL_CNT) begin
        cnt_d = cnt_q + ONE_CNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (run_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign run_full = (cnt_q == FULL_CNT);
  assign last_bit = last_q;

endmodule

// File: rtl/can_dstf_classify.sv
// Decides what the current strobed bit is.
module can_dstf_classify
  import can_dstf_pkg::*;
(
  input  logic      in_valid,
  input  logic      in_bit,
  input  logic      in_sof,
  input  logic      stuff_disable,
  input  logic      run_full,
  input  logic      last_bit,
  output bit_kind_e kind
);

  always_comb begin
    kind = BK_NONE;
    if (in_valid) begin
      if (in_sof || stuff_disable || !run_full) begin
        kind = BK_FRAME;
      end else if (in_bit != last_bit) begin
        kind = BK_STUFF;
      end else begin
        kind = BK_VIOL;
      end
    end
  end

endmodule

// File: rtl/can_dstf_index.sv
// Frame-bit index counter; advances only on forwarded bits.
module can_dstf_index
  import can_dstf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sof,
  input  bit_kind_e        kind,
  output logic [IDX_W-1:0] cur_idx
);

  logic [IDX_W-1:0] next_q, next_d;
  logic             idx_en;

  assign idx_en  = kind_forwards(kind);
  assign cur_idx = in_sof ? '0 : next_q;

  always_comb begin
    next_d = cur_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
    end else if (idx_en) begin
      next_q <= next_d;
    end
  end

endmodule

// File: rtl/can_dstf_outreg.sv
// Output register stage.
module can_dstf_outreg
  import can_dstf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bit_kind_e        kind,
  input  logic             in_bit,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             out_valid,
  output logic             out_bit,
  output logic [IDX_W-1:0] out_index,
  output logic             stuff_flag,
  output logic             stuff_error
);

  logic             fwd_d, flag_d, err_d;
  logic             data_en;

  always_comb begin
    fwd_d   = kind_forwards(kind);
    flag_d  = (kind == BK_STUFF);
    err_d   = (kind == BK_VIOL);
    data_en = fwd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      stuff_flag  <= 1'b0;
      stuff_error <= 1'b0;
    end else begin
      out_valid   <= fwd_d;
      stuff_flag  <= flag_d;
      stuff_error <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit   <= 1'b1;
      out_index <= '0;
    end else if (data_en) begin
      out_bit   <= in_bit;
      out_index <= cur_idx;
    end
  end

endmodule

// File: rtl/can_destuffer.sv
module can_destuffer
  import can_dstf_pkg::*;
#(
  parameter int RUN_LIMIT = 5,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_sof,
  input  logic             stuff_disable,
  output logic             out_valid,
  output logic             out_bit,
  output logic [IDX_W-1:0] out_index,
  output logic             stuff_flag,
  output logic             stuff_error
);

  bit_kind_e        kind;
  logic             run_full;
  logic             last_bit;
  logic [IDX_W-1:0] cur_idx;

  can_dstf_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_sof   (in_sof),
    .kind     (kind),
    .run_full (run_full),
    .last_bit (last_bit)
  );

  can_dstf_classify u_cls (
    .in_valid      (in_valid),
    .in_bit        (in_bit),
    .in_sof        (in_sof),
    .stuff_disable (stuff_disable),
    .run_full      (run_full),
    .last_bit      (last_bit),
    .kind          (kind)
  );

  can_dstf_index #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_sof  (in_sof),
    .kind    (kind),
    .cur_idx (cur_idx)
  );

  can_dstf_outreg #(.IDX_W(IDX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .in_bit      (in_bit),
    .cur_idx     (cur_idx),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .out_index   (out_index),
    .stuff_flag  (stuff_flag),
    .stuff_error (stuff_error)
  );

endmodule

// File: rtl/can_destuffer_chk.sv
module can_destuffer_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_bit,
  input logic             in_sof,
  input logic             stuff_disable,
  input logic             out_valid,
  input logic             out_bit,
  input logic [IDX_W-1:0] out_index,
  input logic             stuff_flag,
  input logic             stuff_error
);

  logic             p_valid, p_sof, p_dis, p_bit, have_idx;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid  <= 1'b0;
      p_sof    <= 1'b0;
      p_dis    <= 1'b0;
      p_bit    <= 1'b0;
      have_idx <= 1'b0;
      last_idx <= '0;
    end else begin
      p_valid <= in_valid;
      p_sof   <= in_sof;
      p_dis   <= stuff_disable;
      p_bit   <= in_bit;
      if (out_valid) begin
        have_idx <= 1'b1;
        last_idx <= out_index;
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && stuff_flag)) else $error("AST_ONE_RESULT");               // R3
  AST_STROBE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || stuff_flag) |-> p_valid) else $error("AST_STROBE_NEEDS_INPUT"); // R9
  AST_INPUT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (out_valid || stuff_flag)) else $error("AST_INPUT_GIVES_RESULT"); // R2
  AST_BIT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bit == p_bit)) else $error("AST_BIT_CARRIED");         // R2
  AST_SOF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_sof) |-> (out_valid && !stuff_error && out_index == '0)) else $error("AST_SOF_CLEAN"); // R6
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !p_sof && have_idx) |-> (out_index == last_idx + IDX_W'(1))) else $error("AST_INDEX_STEP"); // R4
  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && p_dis) |-> (out_valid && !stuff_flag && !stuff_error)) else $error("AST_BYPASS_PASSES"); // R8
  AST_ERROR_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_error |-> out_valid) else $error("AST_ERROR_WITH_BIT");             // R7

endmodule

bind can_destuffer can_destuffer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_bit        (in_bit),
  .in_sof        (in_sof),
  .stuff_disable (stuff_disable),
  .out_valid     (out_valid),
  .out_bit       (out_bit),
  .out_index     (out_index),
  .stuff_flag    (stuff_flag),
  .stuff_error   (stuff_error)
);

// File: tb/can_destuffer_test.sv
`timescale 1ns/1ps
module can_destuffer_test;

  localparam int CLK_P = 10;
  localparam int IDX_W = 10;
  localparam int LIM   = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, in_bit, in_sof, stuff_disable;
  logic             out_valid, out_bit, stuff_flag, stuff_error;
  logic [IDX_W-1:0] out_index;

  always #(CLK_P/2) clk = ~clk;

  can_destuffer #(.RUN_LIMIT(LIM), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_sof(in_sof), .stuff_disable(stuff_disable), .out_valid(out_valid),
    .out_bit(out_bit), .out_index(out_index), .stuff_flag(stuff_flag),
    .stuff_error(stuff_error)
  );

  typedef struct packed {
    logic             stuff;
    logic             err;
    logic             b;
    logic [IDX_W-1:0] idx;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  // reference state derived from the requirements
  int m_run;
  bit m_last;
  int m_idx;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  task automatic send(input bit b, input bit sof, input bit dis, input string tag);
    exp_t e;
    e = '0;
    e.b = b;
    if (sof) begin
      e.idx = '0; m_idx = 1; m_run = 1;
    end else if (!dis && m_run == LIM && b != m_last) begin
      e.stuff = 1'b1; m_run = 1;
    end else if (!dis && m_run == LIM) begin
      e.err = 1'b1; e.idx = IDX_W'(m_idx); m_idx++; m_run = 1;
    end else begin
      e.idx = IDX_W'(m_idx); m_idx++;
      if (b == m_last) m_run = (m_run < LIM) ? m_run + 1 : LIM;
      else m_run = 1;
    end
    m_last = b;
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_sof = sof; stuff_disable = dis;
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  // R9: idle cycles with in_bit toggling must produce nothing
  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        n_chk++;
        if (out_valid || stuff_flag || stuff_error) begin
          n_bad++;
          $display("FAIL R9 idle output act=%b%b%b exp=000", out_valid, stuff_flag, stuff_error);
        end
      end
      in_valid = 1'b0; in_sof = 1'b0; stuff_disable = 1'b0; in_bit = i[0];
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (out_valid || stuff_flag) begin
          n_chk++;
          if (eq.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected output act=%b%b idx=%0d exp=none", out_valid, stuff_flag, out_index);
          end else begin
            exp_t  e;
            string t;
            bit    ok;
            e = eq.pop_front();
            t = tq.pop_front();
            if (e.stuff) ok = stuff_flag && !out_valid && !stuff_error;
            else ok = out_valid && !stuff_flag && (out_bit == e.b) && (out_index == e.idx) && (stuff_error == e.err);
            if (!ok) begin
              n_bad++;
              $display("FAIL %s act(v,f,e,b,idx)=%b%b%b%b/%0d exp(stuff,e,b,idx)=%b%b%b/%0d",
                       t, out_valid, stuff_flag, stuff_error, out_bit, out_index,
                       e.stuff, e.err, e.b, e.idx);
            end
          end
        end else if (eq.size() != 0) begin
          string t;
          void'(eq.pop_front());
          t = tq.pop_front();
          n_chk++; n_bad++;
          $display("FAIL %s missing output act=none exp=one result", t);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0; stuff_disable = 1'b0;
    m_run = 0; m_last = 1'b1; m_idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (out_valid || stuff_flag || stuff_error) begin
      n_bad++;
      $display("FAIL R1 in reset act=%b%b%b exp=000", out_valid, stuff_flag, stuff_error);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (out_valid || stuff_flag || stuff_error) begin
      n_bad++;
      $display("FAIL R1 after reset act=%b%b%b exp=000", out_valid, stuff_flag, stuff_error);
    end

    // Frame A: SOF counts in the run (R6), stuff (R3), run restarted by stuff (R5)
    send(0, 1, 0, "R6");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R2");
    send(1, 0, 0, "R3");
    for (int i = 0; i < 4; i++) send(1, 0, 0, "R5");
    send(0, 0, 0, "R5");
    send(0, 0, 0, "R4");
    send(1, 0, 0, "R4");
    send(0, 0, 0, "R4");
    quiet(4);

    // Frame B: sixth equal bit forwarded with error (R7), run restarts
    send(0, 1, 0, "R6");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R2");
    send(0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R7");
    send(1, 0, 0, "R3");
    quiet(3);

    // SOF clears a stale run of zeros (R6)
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R2");
    send(0, 1, 0, "R6");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R6");
    send(1, 0, 0, "R6");
    quiet(3);

    // Bypass: would-be stuff and error are forwarded (R8); run saturates
    send(0, 1, 0, "R6");
    for (int i = 0; i < 5; i++) send(1, 0, 0, "R2");
    send(0, 0, 1, "R8");
    for (int i = 0; i < 6; i++) send(0, 0, 1, "R8");
    send(0, 0, 0, "R7");
    send(1, 0, 0, "R2");
    quiet(3);

    // Long pseudo-random frame followed by a bypassed recessive tail
    lfsr = 16'hACE1;
    send(0, 1, 0, "R6");
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // bias toward runs by repeating the previous bit often
      send((lfsr[3:0] < 4'd10) ? m_last : lfsr[4], 0, 0, "R4");
    end
    for (int i = 0; i < 11; i++) send(1, 0, 1, "R8");
    quiet(5);

    finished = 1'b1;
    if (eq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 pending act=%0d exp=0", eq.size());
    end
    summary();
    $finish;
  end

endmodule